// File: doc/BRIEF.md
# Interrupt Moderation Timer Pair

This block sits between a completion source and the done interrupt of one transfer direction. Rather than raising an interrupt for every finished packet, it collects completions and raises a single done pulse when one of two timers runs out. The first timer measures how long the oldest waiting completion has been held. The second measures how long the completion stream has been quiet. Each timer can count core clock cycles or the pulses of an external microsecond tick.

Software programs each timer through a small write bus. Each timer has a control word and a limit word. The recommended sequence is to clear the timer, then write its limit, then write enable together with the tick choice. When no timer is enabled, or an enabled timer has a limit of zero, every completion passes straight through. In that case the done output and the early-warning output pulse together. While completions are being held, the early-warning output pulses once when the number of waiting completions reaches a programmable level. This tells the consumer that its buffer is close to overflowing, and it does not disturb the timers.

Top module: `irq_moderator`

## Requirements
- R1: After reset both outputs are low, both timers are disabled and the block is in pass-through.
- R2: When neither timer is enabled, `done_irq` and `hi_irq` each pulse high on the cycle after every cycle in which `cmpl` is high, and they are always equal.
- R3: An enabled timer whose limit is 0 puts the block into pass-through as in R2, whatever the other timer holds.
- R4: With the burst timer enabled at limit T (core-clock ticks), `done_irq` pulses exactly T cycles after the first completion, no matter how many further completions arrive within that window.
- R5: With the idle timer enabled at limit T, every completion restarts it, and `done_irq` pulses exactly T cycles after the last completion.
- R6: When both timers are enabled, whichever expires first fires `done_irq`. The pending count and both timers then return to zero, so no further `done_irq` occurs until a new completion arrives.
- R7: Control bit 2 (external tick) makes a timer advance only on cycles where `us_tick` is high. The done pulse follows the clock edge that carries the T-th tick.
- R8: Control word bit 0 (clear) disables the timer, drops its tick choice and zeroes its count. A control write without bit 0 loads enable from bit 1 and the tick choice from bit 2. The limit is kept.
- R9: Outside pass-through, `hi_irq` pulses once on the cycle after the pending count reaches the level held at address 4. It leaves the timers running, and a level of 0 turns it off.
- R10: Writing a timer's limit zeroes its count, so the next expiry comes a full limit of ticks after that write.
- R11: Write addresses are 0 for the burst control, 1 for the burst limit, 2 for the idle control, 3 for the idle limit and 4 for the warning level. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpl | input | 1 | One-cycle packet completion strobe |
| us_tick | input | 1 | External microsecond tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (R11) |
| wr_data | input | THR_W | Write data |
| done_irq | output | 1 | Moderated done interrupt pulse |
| hi_irq | output | 1 | Early-warning pulse for a pending count near overflow |

## Verification
Several properties are checked on every cycle. A done pulse never appears without pending completions outside pass-through. The two outputs match whenever the block passes completions through. The pending count stays empty in pass-through and only grows between firings. A timer's count stays below its limit. A clear write always leaves the timer stopped at zero. An early-warning pulse always coincides with a pending count equal to the programmed level. Only the bench scenarios can show the exact latencies: T cycles from the first completion for the burst timer, T cycles from the last completion for the idle timer, which timer wins a race, counting by external ticks, and the restart caused by rewriting a limit.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_BURST_CTL = 3'd0,
        A_BURST_THR = 3'd1,
        A_IDLE_CTL  = 3'd2,
        A_IDLE_THR  = 3'd3,
        A_HI_LVL    = 3'd4
    } reg_addr_e;

    localparam int CTL_CLR = 0;
    localparam int CTL_EN  = 1;
    localparam int CTL_EXT = 2;
endpackage

// File: rtl/irqmod_timer.sv
module irqmod_timer
    import irqmod_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] wr_data,
    input  logic             us_tick,
    input  logic             run,
    input  logic             restart,
    output logic             en,
    output logic             thr_zero,
    output logic             expire
);
    typedef struct packed {
        logic             en;
        logic             ext;
        logic [THR_W-1:0] thr;
        logic [THR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic       tick;
    logic       at_last;

    always_comb begin
        s_d      = s_q;
        tick     = s_q.ext ? us_tick : 1'b1;
        at_last  = (s_q.thr != '0) && (s_q.cnt == s_q.thr - 1'b1);
        expire   = s_q.en && run && tick && at_last;
        if (restart) begin
            s_d.cnt = '0;
        end else if (s_q.en && run && tick && (s_q.thr != '0) && !at_last) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (ctl_wr) begin
            if (wr_data[CTL_CLR]) begin
                s_d.en  = 1'b0;
                s_d.ext = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.en  = wr_data[CTL_EN];
                s_d.ext = wr_data[CTL_EXT];
            end
        end
        if (thr_wr) begin
            s_d.thr = wr_data;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en       = s_q.en;
    assign thr_zero = (s_q.thr == '0);

    AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[CTL_CLR] && !thr_wr) |=> (!s_q.en && s_q.cnt == '0)); // R8

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.thr != '0) |-> (s_q.cnt < s_q.thr)); // R10
endmodule

// File: rtl/irqmod_pend.sv
module irqmod_pend #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_wr,
    input  logic [PEND_W-1:0] lvl_data,
    input  logic              cmpl,
    input  logic              fire,
    input  logic              passthru,
    output logic              pend_nz,
    output logic              hi_irq
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic [PEND_W-1:0] lvl;
        logic              hi;
    } pend_state_t;

    pend_state_t       s_d, s_q;
    logic [PEND_W-1:0] base;
    logic              grow;

    always_comb begin
        s_d  = s_q;
        base = fire ? '0 : s_q.pend;
        grow = cmpl && (base != PEND_MAX);
        if (passthru) begin
            s_d.pend = '0;
            s_d.hi   = cmpl;
        end else begin
            s_d.pend = grow ? base + 1'b1 : base;
            s_d.hi   = grow && (s_q.lvl != '0) && (base + 1'b1 == s_q.lvl);
        end
        if (lvl_wr) begin
            s_d.lvl = lvl_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_nz = (s_q.pend != '0);
    assign hi_irq  = s_q.hi;

    AST_PASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        passthru |=> (s_q.pend == '0)); // R2

    AST_PEND_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!passthru && !fire) |=> (s_q.pend >= $past(s_q.pend))); // R6

    AST_HI_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hi && !$past(passthru)) |-> (s_q.pend == $past(s_q.lvl))); // R9
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irqmod_pkg::*;
#(
    parameter int THR_W  = 16,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl,
    input  logic              us_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [THR_W-1:0]  wr_data,
    output logic              done_irq,
    output logic              hi_irq
);
    localparam int N_TMR = 2;

    typedef struct packed {
        logic done;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic [N_TMR-1:0] en_v;
    logic [N_TMR-1:0] tz_v;
    logic [N_TMR-1:0] exp_v;
    logic             pend_nz;
    logic             passthru;
    logic             fire;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam bit IS_IDLE = (g == 1);
        localparam logic [2:0] CTL_A = IS_IDLE ? 3'(A_IDLE_CTL) : 3'(A_BURST_CTL);
        localparam logic [2:0] THR_A = IS_IDLE ? 3'(A_IDLE_THR) : 3'(A_BURST_THR);
        logic restart;

        // idle timer restarts on every completion, burst timer on the first one only
        assign restart = fire || (cmpl && (IS_IDLE || !pend_nz));

        irqmod_timer #(.THR_W(THR_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (wr_en && (wr_addr == CTL_A)),
            .thr_wr   (wr_en && (wr_addr == THR_A)),
            .wr_data  (wr_data),
            .us_tick  (us_tick),
            .run      (pend_nz),
            .restart  (restart),
            .en       (en_v[g]),
            .thr_zero (tz_v[g]),
            .expire   (exp_v[g])
        );
    end

    irqmod_pend #(.PEND_W(PEND_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_wr   (wr_en && (wr_addr == 3'(A_HI_LVL))),
        .lvl_data (wr_data[PEND_W-1:0]),
        .cmpl     (cmpl),
        .fire     (fire),
        .passthru (passthru),
        .pend_nz  (pend_nz),
        .hi_irq   (hi_irq)
    );

    always_comb begin
        passthru = (en_v == '0) || |(en_v & tz_v);
        fire     = !passthru && pend_nz && |exp_v;
        s_d      = s_q;
        s_d.done = passthru ? cmpl : fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_irq = s_q.done;

    AST_DONE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!passthru && !pend_nz) |=> !done_irq); // R6

    AST_PASS_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
        passthru |=> (done_irq == hi_irq)); // R2

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        passthru |=> (done_irq == $past(cmpl))); // R3
endmodule

// File: tb/irq_moderator_test.sv
module irq_moderator_test;
    localparam int THR_W  = 16;
    localparam int PEND_W = 4;
    localparam logic [THR_W-1:0] C_CLR = 16'd1;
    localparam logic [THR_W-1:0] C_EN  = 16'd2;
    localparam logic [THR_W-1:0] C_EXT = 16'd4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmpl = 1'b0;
    logic             us_tick = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [THR_W-1:0] wr_data = '0;
    logic             done_irq;
    logic             hi_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_per = 0;
    logic last_tick = 1'b0;

    irq_moderator #(.THR_W(THR_W), .PEND_W(PEND_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmpl(cmpl), .us_tick(us_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_irq(done_irq), .hi_irq(hi_irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        us_tick = (tick_per != 0) && ((cyc % tick_per) == tick_per - 1);
        last_tick = us_tick;
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr(input logic [2:0] a, input logic [THR_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int bt, input logic [THR_W-1:0] bc,
                       input int it, input logic [THR_W-1:0] ic);
        wr(3'd0, C_CLR);
        wr(3'd2, C_CLR);
        wr(3'd1, THR_W'(bt));
        wr(3'd3, THR_W'(it));
        wr(3'd0, bc);
        wr(3'd2, ic);
    endtask

    // issue one completion (the starting edge)
    task automatic kick();
        cmpl = 1'b1;
        step();
        cmpl = 1'b0;
    endtask

    // steps until done; extra completions on the first 'extra' steps
    task automatic measure(input int extra, output int n, output int ticks,
                           output int hi_first, output int hi_cnt);
        n = 0; ticks = 0; hi_first = -1; hi_cnt = 0;
        for (int k = 1; k <= 80; k++) begin
            cmpl = (k <= extra);
            step();
            if (last_tick) ticks++;
            if (hi_irq) begin
                hi_cnt++;
                if (hi_first < 0) hi_first = k;
            end
            if (done_irq) begin
                n = k;
                break;
            end
        end
        cmpl = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, tk, hf, hc;
        repeat (3) @(negedge clk);
        chk("R1 done at reset", int'(done_irq), 0);
        chk("R1 hi at reset", int'(hi_irq), 0);
        rst_n = 1'b1;
        step();
        kick();
        chk("R1 pass-through after reset", int'(done_irq), 1);

        // R2: both disabled, pattern sweep
        for (int p = 0; p < 16; p++) begin
            logic bit_now;
            bit_now = ((p * 7) % 3) == 0;
            cmpl = bit_now;
            step();
            chk("R2 done follows cmpl", int'(done_irq), int'(bit_now));
            chk("R2 hi equals done", int'(hi_irq), int'(done_irq));
        end
        cmpl = 1'b0;

        // R3: zero limit on an enabled timer
        cfg(0, C_EN, 0, 16'd0);
        kick();
        chk("R3 burst limit 0 passes", int'(done_irq), 1);
        cfg(5, C_EN, 0, C_EN);
        kick();
        chk("R3 idle limit 0 passes", int'(done_irq), 1);
        chk("R3 hi twin", int'(hi_irq), 1);

        // R4: burst sweep
        for (int t = 1; t <= 6; t++) begin
            cfg(t, C_EN, 0, 16'd0);
            kick();
            measure(0, n, tk, hf, hc);
            chk("R4 burst single", n, t);
            cfg(t, C_EN, 0, 16'd0);
            kick();
            measure(t - 1, n, tk, hf, hc);
            chk("R4 burst with extra completions", n, t);
        end

        // R5: idle sweep
        for (int t = 2; t <= 6; t++) begin
            cfg(0, 16'd0, t, C_EN);
            kick();
            measure(0, n, tk, hf, hc);
            chk("R5 idle single", n, t);
            kick();
            measure(3, n, tk, hf, hc);
            chk("R5 idle restarts", n, 3 + t);
        end

        // R6: race between timers, then quiet
        cfg(4, C_EN, 10, C_EN);
        kick();
        measure(3, n, tk, hf, hc);
        chk("R6 burst wins", n, 4);
        cfg(10, C_EN, 3, C_EN);
        kick();
        measure(0, n, tk, hf, hc);
        chk("R6 idle wins", n, 3);
        hc = 0;
        for (int k = 0; k < 15; k++) begin
            step();
            if (done_irq) hc++;
        end
        chk("R6 no done after firing", hc, 0);

        // R7: external tick
        tick_per = 4;
        cfg(3, C_EN | C_EXT, 0, 16'd0);
        kick();
        measure(0, n, tk, hf, hc);
        chk("R7 burst counts ticks", tk, 3);
        chk("R7 fires on tick edge", int'(last_tick), 1);
        chk("R7 slower than clock", int'(n > 3), 1);
        tick_per = 3;
        cfg(0, 16'd0, 2, C_EN | C_EXT);
        kick();
        measure(0, n, tk, hf, hc);
        chk("R7 idle counts ticks", tk, 2);
        tick_per = 0;

        // R8: clear mid-count, then re-enable without rewriting limit
        cfg(6, C_EN, 0, 16'd0);
        kick();
        step(); step(); step();
        wr(3'd0, C_CLR);
        hc = 0;
        for (int k = 0; k < 8; k++) begin
            step();
            if (done_irq) hc++;
        end
        chk("R8 clear drops held done", hc, 0);
        kick();
        chk("R8 clear leaves pass-through", int'(done_irq), 1);
        wr(3'd0, C_EN);
        kick();
        measure(0, n, tk, hf, hc);
        chk("R8 limit kept, count zeroed", n, 6);

        // R9: early warning
        cfg(12, C_EN, 0, 16'd0);
        wr(3'd4, 16'd3);
        kick();
        measure(4, n, tk, hf, hc);
        chk("R9 hi at third completion", hf, 2);
        chk("R9 hi once", hc, 1);
        chk("R9 timers undisturbed", n, 12);
        wr(3'd4, 16'd0);
        kick();
        measure(4, n, tk, hf, hc);
        chk("R9 level 0 silent", hc, 0);

        // R10: limit rewrite restarts count
        cfg(8, C_EN, 0, 16'd0);
        kick();
        step(); step(); step(); step();
        wr(3'd1, 16'd5);
        measure(0, n, tk, hf, hc);
        chk("R10 restart after limit write", n, 5);

        // R11: level address and idle address decode
        cfg(0, 16'd0, 4, C_EN);
        wr(3'd4, 16'd2);
        kick();
        measure(2, n, tk, hf, hc);
        chk("R11 level written at address 4", hf, 1);
        chk("R11 idle at address 3", n, 6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule